// File: doc/BRIEF.md
# Dual-Processor Mailbox Signalling Controller

This block lets two processors signal each other over up to sixteen one-bit channels through one word-wide register bus. Each channel holds one occupied flag per processor. The flag belongs to the sending processor. The sender raises its flag for a channel to post a message. The receiver acknowledges by clearing that same flag, which frees the channel again for the sender.

Each processor has a bank of four registers:

- a control word with two global interrupt enables;
- a mask word whose low half masks receive events and whose high half masks transmit events;
- a set/clear word that can only be written;
- a status word that shows the flags this processor has raised.

Both status words can be read from either side, so each processor can see its peer's flags. Two read-only words at the top of the map report the number of channels and the revision.

Each processor has two registered, level-sensitive interrupt lines. The receive line goes high while the peer has raised an unmasked flag. The transmit line goes high while one of the processor's own unmasked channels is free.

Top module: `mbox_sig_ctrl`

## Requirements
- R1: After reset, every occupied flag and both control enables are 0. Every mask bit reads 1, so all four interrupt lines are low.
- R2: Writing 1 to bit 16+n of bank p's set/clear word (offset 0x8 in the bank) sets processor p's flag n. Bit n of bank p's status word (offset 0xC) then reads 1. Bits written as 0 change nothing.
- R3: Writing 1 to bit n (n < 16) of bank p's set/clear word clears the peer's flag n. Bits written as 0 change nothing.
- R4: The receive line of processor p is high when control bit 0 of bank p is 1 and some channel n has the peer's flag set while bank p's mask bit n is 0.
- R5: The transmit line of processor p is high when control bit 16 of bank p is 1 and some implemented channel n has p's own flag clear while bank p's mask bit 16+n is 0.
- R6: Only bits 0 and 16 of the control word are stored. Every other control bit reads 0.
- R7: Mask bits n and 16+n are writable for each implemented channel n. The mask bits of unimplemented channels always read 1.
- R8: The set/clear word reads as zero.
- R9: Offset 0x3F0 returns the channel count in bits 7:0. Offset 0x3F4 returns the major revision in bits 7:4 and the minor revision in bits 3:0. Writes to either offset are ignored.
- R10: Bank 0 starts at offset 0x000 and bank 1 at 0x010. Either bank's status word can be read at its own offset, so a processor reaches its peer's status 0x10 above or below its own.
- R11: Read data appears in the cycle after the read request and is zero when no read is requested. Offsets that are not defined read as zero and ignore writes.
- R12: An interrupt line changes one clock after the flag, mask or enable state that drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_rx | output | 2 | Receive-occupied interrupt, one per processor |
| irq_tx | output | 2 | Transmit-free interrupt, one per processor |

## Verification
The bench builds the block with four channels and revision 2.3. With four channels, every pattern of sender flags can be swept against every pattern of masks, in both directions between the processors. Four channels also leaves twelve unimplemented channel positions, so the bench can check that their mask bits stay at 1 and that they never raise an interrupt. The revision values are deliberately different from the defaults, so the identification words are shown to follow the parameters.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int HALF_W = 16;
  localparam int CTRL_RX_BIT = 0;
  localparam int CTRL_TX_BIT = 16;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_MASK   = 2'd1,
    REG_SETCLR = 2'd2,
    REG_STAT   = 2'd3
  } bank_reg_e;
endpackage

// File: rtl/mbox_bank_regs.sv
module mbox_bank_regs #(
  parameter int NUM_CHAN = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_ctrl,
  input  logic                wr_mask,
  input  logic [31:0]         wdata,
  output logic                en_rx,
  output logic                en_tx,
  output logic [NUM_CHAN-1:0] mask_rx,
  output logic [NUM_CHAN-1:0] mask_tx
);
  import mbox_pkg::*;

  wire unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_rx   <= 1'b0;
      en_tx   <= 1'b0;
      mask_rx <= '1;
      mask_tx <= '1;
    end else begin
      if (wr_ctrl) begin
        en_rx <= wdata[CTRL_RX_BIT];
        en_tx <= wdata[CTRL_TX_BIT];
      end
      if (wr_mask) begin
        mask_rx <= wdata[NUM_CHAN-1:0];
        mask_tx <= wdata[HALF_W +: NUM_CHAN];
      end
    end
  end

  // R6: enables move only on a control write
  a_r6_ctrl_stable: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable({en_rx, en_tx}));
  // R7: masks move only on a mask write
  a_r7_mask_stable: assert property (@(posedge clk) disable iff (rst)
    !wr_mask |=> $stable({mask_rx, mask_tx}));
endmodule

// File: rtl/mbox_flag_store.sv
module mbox_flag_store #(
  parameter int NUM_CHAN = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0][NUM_CHAN-1:0] set_v,
  input  logic [1:0][NUM_CHAN-1:0] clr_v,
  output logic [1:0][NUM_CHAN-1:0] flags
);
  for (genvar p = 0; p < 2; p++) begin : g_proc
    always_ff @(posedge clk) begin
      if (rst) flags[p] <= '0;
      else     flags[p] <= (flags[p] & ~clr_v[p]) | set_v[p];
    end

    // R2: a requested set is visible on the next cycle
    a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
      (|set_v[p]) |=> ((flags[p] & $past(set_v[p])) == $past(set_v[p])));
    // R3: a requested clear without a set drops the flag
    a_r3_clr_lands: assert property (@(posedge clk) disable iff (rst)
      ((|clr_v[p]) && !(|set_v[p])) |=> ((flags[p] & $past(clr_v[p])) == '0));
    // R11: flags hold when no request is pending
    a_r11_flags_hold: assert property (@(posedge clk) disable iff (rst)
      (!(|set_v[p]) && !(|clr_v[p])) |=> $stable(flags[p]));
  end
endmodule

// File: rtl/mbox_irq_unit.sv
module mbox_irq_unit #(
  parameter int NUM_CHAN = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_rx,
  input  logic                en_tx,
  input  logic [NUM_CHAN-1:0] mask_rx,
  input  logic [NUM_CHAN-1:0] mask_tx,
  input  logic [NUM_CHAN-1:0] own_flags,
  input  logic [NUM_CHAN-1:0] peer_flags,
  output logic                irq_rx,
  output logic                irq_tx
);
  logic rx_pend, tx_pend;

  always_comb begin
    rx_pend = |(peer_flags & ~mask_rx);
    tx_pend = |(~own_flags & ~mask_tx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_rx <= 1'b0;
      irq_tx <= 1'b0;
    end else begin
      irq_rx <= en_rx & rx_pend;
      irq_tx <= en_tx & tx_pend;
    end
  end

  // R4: receive line gated by its enable
  a_r4_rx_gated: assert property (@(posedge clk) disable iff (rst)
    !en_rx |=> !irq_rx);
  // R5: transmit line gated by its enable
  a_r5_tx_gated: assert property (@(posedge clk) disable iff (rst)
    !en_tx |=> !irq_tx);
  // R4: fully masked receive side stays quiet
  a_r4_rx_masked: assert property (@(posedge clk) disable iff (rst)
    (&mask_rx) |=> !irq_rx);
endmodule

// File: rtl/mbox_sig_ctrl.sv
module mbox_sig_ctrl #(
  parameter int         NUM_CHAN  = 16,
  parameter int         ADDR_W    = 10,
  parameter logic [3:0] REV_MAJOR = 4'd1,
  parameter logic [3:0] REV_MINOR = 4'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [1:0]        irq_rx,
  output logic [1:0]        irq_tx
);
  import mbox_pkg::*;

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] HWCFG_ADDR = ADDR_W'(10'h3F0);
  localparam logic [ADDR_W-1:0] VER_ADDR   = ADDR_W'(10'h3F4);

  logic      in_bank, bank_id, is_hwcfg, is_ver;
  bank_reg_e reg_sel;
  logic [1:0] wr_ctrl, wr_mask, wr_sc;
  logic [1:0][NUM_CHAN-1:0] set_v, clr_v, flags, mask_rx, mask_tx;
  logic [1:0] en_rx, en_tx;
  logic [31:0] rd_next;

  wire unused_addr = ^bus_addr[1:0];

  always_comb begin
    in_bank  = (bus_addr[ADDR_W-1:5] == '0);
    bank_id  = bus_addr[4];
    reg_sel  = bank_reg_e'(bus_addr[3:2]);
    is_hwcfg = (bus_addr[ADDR_W-1:2] == HWCFG_ADDR[ADDR_W-1:2]);
    is_ver   = (bus_addr[ADDR_W-1:2] == VER_ADDR[ADDR_W-1:2]);
  end

  for (genvar p = 0; p < 2; p++) begin : g_bank
    localparam int Q = 1 - p;
    logic hit;
    assign hit        = bus_sel && bus_wr && in_bank && (bank_id == 1'(p));
    assign wr_ctrl[p] = hit && (reg_sel == REG_CTRL);
    assign wr_mask[p] = hit && (reg_sel == REG_MASK);
    assign wr_sc[p]   = hit && (reg_sel == REG_SETCLR);
    assign set_v[p]   = wr_sc[p] ? bus_wdata[HALF_W +: NUM_CHAN] : '0;
    assign clr_v[Q]   = wr_sc[p] ? bus_wdata[NUM_CHAN-1:0] : '0;

    mbox_bank_regs #(.NUM_CHAN(NUM_CHAN)) i_regs (
      .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl[p]), .wr_mask(wr_mask[p]),
      .wdata(bus_wdata), .en_rx(en_rx[p]), .en_tx(en_tx[p]),
      .mask_rx(mask_rx[p]), .mask_tx(mask_tx[p]));

    mbox_irq_unit #(.NUM_CHAN(NUM_CHAN)) i_irq (
      .clk(clk), .rst(rst), .en_rx(en_rx[p]), .en_tx(en_tx[p]),
      .mask_rx(mask_rx[p]), .mask_tx(mask_tx[p]),
      .own_flags(flags[p]), .peer_flags(flags[Q]),
      .irq_rx(irq_rx[p]), .irq_tx(irq_tx[p]));
  end

  mbox_flag_store #(.NUM_CHAN(NUM_CHAN)) i_flags (
    .clk(clk), .rst(rst), .set_v(set_v), .clr_v(clr_v), .flags(flags));

  always_comb begin
    rd_next = '0;
    if (in_bank) begin
      unique case (reg_sel)
        REG_CTRL: begin
          rd_next[CTRL_RX_BIT] = en_rx[bank_id];
          rd_next[CTRL_TX_BIT] = en_tx[bank_id];
        end
        REG_MASK: begin
          rd_next = '1;
          rd_next[NUM_CHAN-1:0]       = mask_rx[bank_id];
          rd_next[HALF_W +: NUM_CHAN] = mask_tx[bank_id];
        end
        REG_SETCLR: rd_next = '0;
        REG_STAT:   rd_next[NUM_CHAN-1:0] = flags[bank_id];
        default:    rd_next = '0;
      endcase
    end else if (is_hwcfg) begin
      rd_next[7:0] = 8'(NUM_CHAN);
    end else if (is_ver) begin
      rd_next[7:0] = {REV_MAJOR, REV_MINOR};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_next;
    else                         bus_rdata <= '0;
  end

  // R8: set/clear word reads zero
  a_r8_setclr_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && in_bank && reg_sel == REG_SETCLR) |=> (bus_rdata == '0));
  // R11: idle bus returns zero
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> (bus_rdata == '0));
  // R11: writes outside the banks leave flags untouched
  a_r11_undef_wr: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && !in_bank) |=> $stable(flags));
endmodule

// File: tb/test_mbox_sig_ctrl.sv
module test_mbox_sig_ctrl;
  localparam int C = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic sel = 1'b0, wr_en = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0] irq_rx, irq_tx;
  int n_chk = 0, n_fail = 0;
  logic [31:0] rv;
  localparam logic [31:0] IMPL = 32'h000F_000F;

  always #4 clk = ~clk;

  mbox_sig_ctrl #(.NUM_CHAN(C), .ADDR_W(10), .REV_MAJOR(4'd2), .REV_MINOR(4'd3)) i_mbox_sig_ctrl (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr_en), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_rx(irq_rx), .irq_tx(irq_tx));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr_en = 1'b0; addr = a;
    @(negedge clk); d = rdata; sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 irq", {28'd0, irq_rx, irq_tx}, 32'd0);
    chk("R11 idle rdata", rdata, 32'd0);
    for (int b = 0; b < 2; b++) begin
      rd(10'(b * 16 + 0), rv);  chk("R1 ctrl", rv, 32'd0);
      rd(10'(b * 16 + 4), rv);  chk("R1 mask", rv, 32'hFFFF_FFFF);
      rd(10'(b * 16 + 12), rv); chk("R1 status", rv, 32'd0);
    end
    // R9 identification words, R8 set/clear reads zero
    rd(10'h3F0, rv); chk("R9 hwcfg", rv, 32'd4);
    rd(10'h3F4, rv); chk("R9 version", rv, 32'h23);
    wr(10'h3F0, 32'hFF); wr(10'h3F4, 32'hFF);
    rd(10'h3F0, rv); chk("R9 hwcfg ro", rv, 32'd4);
    rd(10'h3F4, rv); chk("R9 version ro", rv, 32'h23);
    // R6 control word storage
    wr(10'h000, 32'hFFFF_FFFF);
    rd(10'h000, rv); chk("R6 ctrl bits", rv, 32'h0001_0001);
    // R7 mask storage with unimplemented bits stuck at 1
    wr(10'h014, 32'h1234_5678);
    rd(10'h014, rv); chk("R7 mask", rv, 32'h1234_5678 | ~IMPL);
    wr(10'h014, 32'h0);
    rd(10'h014, rv); chk("R7 mask zero", rv, ~IMPL);
    // R2 set, R10 bank placement, peer status visible
    wr(10'h000, 32'h0); wr(10'h004, 32'hFFFF_FFFF); wr(10'h014, 32'hFFFF_FFFF);
    wr(10'h008, 32'h000F_0000);
    rd(10'h00C, rv); chk("R2 own status", rv, 32'hF);
    rd(10'h01C, rv); chk("R10 peer status", rv, 32'h0);
    wr(10'h018, 32'h0002_0000);
    rd(10'h01C, rv); chk("R10 bank1 status", rv, 32'h2);
    rd(10'h008, rv); chk("R8 setclr read", rv, 32'h0);
    // R3 clear by peer, zero bits inert
    wr(10'h018, 32'h0000_0005);
    rd(10'h00C, rv); chk("R3 clear", rv, 32'hA);
    wr(10'h008, 32'h0);
    rd(10'h00C, rv); chk("R2 zero write", rv, 32'hA);
    rd(10'h01C, rv); chk("R3 zero write", rv, 32'h2);
    // R11 undefined offsets
    wr(10'h020, 32'hFFFF_FFFF); wr(10'h100, 32'hFFFF_FFFF);
    rd(10'h020, rv); chk("R11 undef read", rv, 32'h0);
    rd(10'h100, rv); chk("R11 undef read2", rv, 32'h0);
    rd(10'h00C, rv); chk("R11 undef write", rv, 32'hA);
    // clean flags
    wr(10'h008, 32'hF); wr(10'h018, 32'hF);
    // R12 latency and R4 enable gate
    wr(10'h010, 32'h0000_0000); wr(10'h014, 32'hFFFF_FFF0);
    wr(10'h008, 32'h0001_0000);
    @(negedge clk); chk("R4 rx disabled", {31'd0, irq_rx[1]}, 32'd0);
    @(negedge clk); sel = 1'b1; wr_en = 1'b1; addr = 10'h010; wdata = 32'h1;
    @(negedge clk); sel = 1'b0; wr_en = 1'b0;
    chk("R12 before", {31'd0, irq_rx[1]}, 32'd0);
    @(negedge clk); chk("R12 after", {31'd0, irq_rx[1]}, 32'd1);
    wr(10'h008, 32'hF); wr(10'h018, 32'hF);
    // R4/R5 exhaustive sweep over flag and mask patterns
    wr(10'h000, 32'h0001_0001); wr(10'h010, 32'h0001_0001);
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 16; s++) begin
        for (int m = 0; m < 16; m++) begin
          logic [9:0] bp, bq;
          logic [3:0] s4, m4;
          bit erx, etx;
          s4 = 4'(s); m4 = 4'(m);
          bp = 10'(p * 16); bq = 10'((1 - p) * 16);
          wr(bq + 10'h8, 32'hF);
          wr(bq + 10'h4, {16'hFFFF, 12'hFFF, m4});
          wr(bp + 10'h4, {12'hFFF, m4, 16'hFFFF});
          wr(bp + 10'h8, {12'd0, s4, 16'd0});
          @(negedge clk);
          erx = |(s4 & ~m4);
          etx = |(~s4 & ~m4);
          chk("R4 rx sweep", {31'd0, irq_rx[1 - p]}, {31'd0, erx});
          chk("R5 tx sweep", {31'd0, irq_tx[p]}, {31'd0, etx});
          chk("R4 rx quiet", {31'd0, irq_rx[p]}, 32'd0);
          chk("R5 tx masked", {31'd0, irq_tx[1 - p]}, 32'd0);
        end
      end
      wr(10'((1 - p) * 16 + 8), 32'hF);
      wr(10'(p * 16 + 4), 32'hFFFF_FFFF);
      wr(10'((1 - p) * 16 + 4), 32'hFFFF_FFFF);
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule